// File: doc/BRIEF.md
# Handshake and Width Bridging Converter

This glue block joins a byte-wide producer to a word-wide consumer whose handshakes do not line up. The producer raises a request and expects an acknowledge in the very next cycle. It then writes one byte, and it writes further bytes only while a "more" control is high. The consumer takes a request and answers with its own acknowledge. It then reads one two-byte word when a data-ready strobe appears. Neither peer drives "more" or data-ready, so the converter generates both.

The converter latches the producer's request and answers it on its own in the following cycle. It forwards the request to the consumer and holds it there until the consumer acknowledges. Only after that does it accept bytes. It packs two bytes into a word and presents the word together with a one-cycle data-ready pulse. An occupancy count of buffered bytes stays between 0 and 2. Any strobe or request that would break the count or the ordering is absorbed and goes no further.

Top module: `hs_width_bridge`

## Requirements
- R1: A synchronous active-high reset returns the block to idle with an empty buffer, and every output is then 0 (prod_ack, prod_more, cons_req, cons_rdy and cons_data).
- R2: A producer request seen while idle makes prod_ack high for exactly one cycle, the cycle after the request, whatever the consumer does.
- R3: cons_req goes high in the same cycle as prod_ack and stays high up to and including the cycle in which cons_ack is sampled high. It is never high unless a producer request was accepted.
- R4: prod_more is high exactly in the cycles where the block accepts bytes and holds one byte.
- R5: The first byte accepted appears on cons_data[7:0] and the second on cons_data[15:8].
- R6: cons_rdy is high for exactly one cycle, the cycle after the second byte is written. The buffer is empty again in the next cycle.
- R7: A data strobe is absorbed, with no effect on the word delivered, when it comes while idle, before the consumer has acknowledged the request, or while the buffer is full.
- R8: A producer request that arrives while a transfer is in progress is absorbed: it raises no extra prod_ack and no extra cons_req.
- R9: Occupancy never leaves 0..2. A word is read only when the count is 2, and after a drain no read occurs until the count is 2 again.
- R10: The block takes at most one transition per clock. If cons_ack and a data strobe arrive together in the acknowledge cycle, the acknowledge is taken and that strobe is absorbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_req | input | 1 | Request from the producer |
| prod_wr | input | 1 | Producer byte-valid strobe |
| prod_data | input | BYTE_W | Producer byte |
| prod_ack | output | 1 | Acknowledge to the producer |
| prod_more | output | 1 | Generated "send another byte" control |
| cons_req | output | 1 | Request forwarded to the consumer |
| cons_ack | input | 1 | Acknowledge from the consumer |
| cons_rdy | output | 1 | Generated data-ready strobe |
| cons_data | output | 2*BYTE_W | Packed word |

## Verification
The bench builds the block with the default BYTE_W of 8. At that width the byte values used in the tests are distinct, so any swap of halves, stale half or absorbed byte that leaks into the word is visible on cons_data. The directed phases cover consumer acknowledges that come early, late and together with a strobe. They also cover stray strobes and requests in every phase. A long pseudo-random phase then mixes all four inputs, so that every state meets every input combination.

// File: rtl/hs_width_bridge.sv
module hs_width_bridge #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prod_req,
  input  logic                prod_wr,
  input  logic [BYTE_W-1:0]   prod_data,
  output logic                prod_ack,
  output logic                prod_more,
  output logic                cons_req,
  input  logic                cons_ack,
  output logic                cons_rdy,
  output logic [2*BYTE_W-1:0] cons_data
);

  localparam int OCC_W = 2;
  localparam logic [OCC_W-1:0] OCC_FULL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_GRANT, S_WAIT, S_FILL, S_FULL} st_t;

  st_t              st;
  logic [OCC_W-1:0] occ;
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      occ  <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (prod_req) st <= S_GRANT;
        S_GRANT: st <= cons_ack ? S_FILL : S_WAIT;
        S_WAIT:  if (cons_ack) st <= S_FILL;
        S_FILL: begin
          if (prod_wr) begin
            if (occ == '0) begin
              lo_q <= prod_data;
              occ  <= 2'd1;
            end else begin
              hi_q <= prod_data;
              occ  <= OCC_FULL;
              st   <= S_FULL;
            end
          end
        end
        S_FULL: begin
          occ <= '0;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign prod_ack  = (st == S_GRANT);
  assign cons_req  = (st == S_GRANT) || (st == S_WAIT);
  assign prod_more = (st == S_FILL) && (occ == 2'd1);
  assign cons_rdy  = (st == S_FULL);
  assign cons_data = {hi_q, lo_q};

  // R9
  occ_range_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_FULL);

  // R9
  read_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    cons_rdy |-> occ == OCC_FULL);

  // R2
  ack_next_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && prod_req) |=> prod_ack);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    prod_ack |=> !prod_ack);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cons_req && !cons_ack) |=> cons_req);

  // R4
  more_one_byte_chk: assert property (@(posedge clk) disable iff (rst)
    prod_more |-> (occ == 2'd1 && !cons_req));

  // R6
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cons_rdy |=> (!cons_rdy && occ == '0));

  // R7
  full_absorb_chk: assert property (@(posedge clk) disable iff (rst)
    cons_rdy |=> $stable(cons_data));

endmodule

// File: tb/test_hs_width_bridge.sv
`timescale 1ns/1ps
module test_hs_width_bridge;
  logic        clk = 0;
  logic        rst, prod_req, prod_wr, cons_ack;
  logic [7:0]  prod_data;
  logic        prod_ack, prod_more, cons_req, cons_rdy;
  logic [15:0] cons_data;

  int errors = 0, checks = 0;
  bit done = 0;

  int  mode = 0;
  byte unsigned q[$];

  always #2 clk = ~clk;

  hs_width_bridge #(.BYTE_W(8)) i_hs_width_bridge (
    .clk(clk), .rst(rst), .prod_req(prod_req), .prod_wr(prod_wr),
    .prod_data(prod_data), .prod_ack(prod_ack), .prod_more(prod_more),
    .cons_req(cons_req), .cons_ack(cons_ack), .cons_rdy(cons_rdy),
    .cons_data(cons_data));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic rq, input logic wr,
                      input logic [7:0] d, input logic ak);
    rst = r; prod_req = rq; prod_wr = wr; prod_data = d; cons_ack = ak;
    #1;
    if (!r) begin
      chk("R2 prod_ack", prod_ack, (mode == 1));
      chk("R3/R8 cons_req", cons_req, (mode == 1 || mode == 2));
      chk("R4 prod_more", prod_more, (mode == 3 && q.size() == 1));
      chk("R6/R9 cons_rdy", cons_rdy, (mode == 4));
      if (mode == 4) chk("R5/R7 cons_data", cons_data, {q[1], q[0]});
    end
    @(posedge clk);
    if (r) begin
      mode = 0; q.delete();
    end else begin
      case (mode)
        0: if (rq) mode = 1;
        1: mode = ak ? 3 : 2;
        2: if (ak) mode = 3;
        3: if (wr) begin
             q.push_back(d);
             if (q.size() == 2) mode = 4;
           end
        default: begin q.delete(); mode = 0; end
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    step(1, 0, 0, 8'h00, 0);
    step(1, 1, 1, 8'hFF, 1);
    // R1: reset state
    #1;
    chk("R1 outputs", {prod_ack, prod_more, cons_req, cons_rdy}, 16'h0);
    chk("R1 data", cons_data, 16'h0000);
    step(0, 0, 0, 8'h00, 0);
    // R7: strobe while idle absorbed
    step(0, 0, 1, 8'hEE, 0);
    // R2, R3: basic transfer, consumer acks at once
    step(0, 1, 0, 8'h00, 0);
    step(0, 0, 0, 8'h00, 1);
    step(0, 0, 1, 8'hA1, 0);
    step(0, 0, 1, 8'hB2, 0);
    // R5, R6: word B2A1 delivered here
    step(0, 0, 0, 8'h00, 0);
    step(0, 0, 0, 8'h00, 0);
    // R3, R7: delayed consumer ack, early strobes absorbed
    step(0, 1, 0, 8'h00, 0);
    step(0, 0, 1, 8'h11, 0);
    step(0, 0, 1, 8'h22, 0);
    step(0, 1, 1, 8'h33, 0);
    step(0, 0, 0, 8'h00, 1);
    // R4, R8: gap between bytes, request during fill absorbed
    step(0, 0, 1, 8'h44, 0);
    step(0, 1, 0, 8'h00, 0);
    step(0, 0, 0, 8'h00, 0);
    step(0, 0, 1, 8'h55, 0);
    // R7: strobe while full absorbed
    step(0, 0, 1, 8'h66, 0);
    step(0, 0, 0, 8'h00, 0);
    // R10: ack and strobe together in acknowledge cycle
    step(0, 1, 0, 8'h00, 0);
    step(0, 0, 1, 8'h77, 1);
    step(0, 0, 1, 8'h88, 0);
    step(0, 0, 1, 8'h99, 0);
    step(0, 0, 0, 8'h00, 0);
    // mid-transfer reset (R1)
    step(0, 1, 0, 8'h00, 0);
    step(1, 0, 0, 8'h00, 0);
    #1;
    chk("R1 after reset", {prod_ack, prod_more, cons_req, cons_rdy}, 16'h0);
    // pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(0, lf[0] & lf[3], lf[1] | lf[5], lf[15:8], lf[2] & lf[6]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule